// File: doc/BRIEF.md
# Packet-Granular Ingress Bus Receiver

This block is the receiving end of a 32-bit parallel bus that carries fixed-length packets from a packet-processing device into a switch-side converter. It drives a receive-enable back to the sender, registers every bus input, frames packets from a one-cycle start strobe, and stores complete packets in an internal FIFO that a downstream consumer reads with a show-ahead pop interface. Throttling happens only between packets. Once a packet has begun, one word is taken on every clock until its last word, whatever the enable and availability signals do.

The enable is computed from FIFO space alone. Space is reserved for a whole packet as soon as one is accepted, so the enable drops early enough for the sender to hold off the next packet. A packet becomes visible to the reader only after its last word is stored. A packet that is cut short by a new start strobe is erased and flagged as an error. A second operating mode, for systems that carry flow control inside the packet headers, ignores the sender's availability signal and throws away packets whose header marks them as idle.

`PKT_WORDS` must be at least 5, and `PKT_WORDS * FIFO_PKTS` must be a power of two.

Top module: `pkt_ingress_rx`

## Requirements
- R1: While `rst_ni` is low, `rx_en_o` and `proto_err_o` are 0 and `rd_empty_o` is 1. With an empty FIFO, `rx_en_o` is 1 after the first rising edge following reset release.
- R2: `rx_en_o` is a register set when committed free space, less `PKT_WORDS` for an accepted packet still arriving, is at least `PKT_WORDS`. It does not depend on `pkt_avail_i`, and it is low while the FIFO holds no room for another packet.
- R3: When an accepted packet leaves room for no further packet, `rx_en_o` falls on the third rising edge after the clock in which its start word is on the bus. It is therefore low at least two cycles before the last word.
- R4: After a start strobe, `PKT_WORDS` consecutive words are captured, one per clock, even if `rx_en_o` or `pkt_avail_i` fall. A stored packet is read back in order, and `rd_empty_o` falls on the second rising edge after its last word was on the bus.
- R5: With `inband_i` = 0, a start strobe seen while `pkt_avail_i` is 0 makes the whole packet ignored.
- R6: Bus words with `sop_i` = 0 that arrive outside a packet are ignored.
- R7: A packet whose start finds less than `PKT_WORDS` of committed free space is dropped whole. The FIFO never holds more than its depth.
- R8: With `inband_i` = 1, `pkt_avail_i` is ignored, and a packet whose first word has bit 31 set is discarded. With `inband_i` = 0, such a packet is stored unchanged.
- R9: A start strobe during a packet sets `proto_err_o` on the second rising edge after that strobe is on the bus. The flag stays set until reset. The partial packet is erased, and the new packet is captured in full.
- R10: `rd_i` with `rd_empty_o` = 0 pops one word, and `rd_data_o` shows the head word. Popping frees space, and `rx_en_o` rises one edge after free space reaches `PKT_WORDS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inband_i | input | 1 | 1 selects header-carried flow control mode |
| pkt_avail_i | input | 1 | Sender has at least one whole packet ready |
| sop_i | input | 1 | One-cycle start-of-packet strobe |
| data_i | input | 32 | Bus word; the first word is the header |
| rx_en_o | output | 1 | Receiver has room for a whole packet |
| proto_err_o | output | 1 | Sticky flag for a start strobe inside a packet |
| rd_i | input | 1 | Pop the head word of the FIFO |
| rd_data_o | output | 32 | Head word of the FIFO (show-ahead) |
| rd_empty_o | output | 1 | No complete packet word available |

## Verification
Every bus-side result trails its cause by a fixed number of rising edges, because the inputs pass through a register before framing. The enable reacts on the third edge after a start word is on the bus. A finished packet becomes readable on the second edge after its last word. The error flag rises on the second edge after an offending strobe, and the enable recovers one edge after the pop that frees a packet's worth of space. The bench drives and samples only on falling edges, records `rx_en_o` and `proto_err_o` before each word it drives, and checks each result at the falling edge that follows exactly that many rising edges. For each of these latencies it also checks the falling edge just before, where the old value must still hold.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam int DATA_W = 32;

  typedef logic [DATA_W-1:0] word_t;

  // registered bus inputs
  typedef struct packed {
    logic  sop;
    logic  avail;
    logic  inband;
    word_t data;
  } bus_in_t;

  // framing -> storage commands
  typedef struct packed {
    logic abort;
    logic start;
    logic push;
    logic commit;
  } fifo_op_t;
endpackage

// File: rtl/pkt_rx_frame.sv
module pkt_rx_frame
  import pkt_rx_pkg::*;
#(
  parameter int PKT_WORDS = 16,
  parameter int IDLE_BIT  = DATA_W - 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  bus_in_t  bus_i,
  input  logic     room_i,
  output fifo_op_t op_o,
  output word_t    wdata_o,
  output logic     hold_o,
  output logic     err_o
);
  localparam int CW = $clog2(PKT_WORDS);
  localparam logic [CW-1:0] LAST = CW'(PKT_WORDS - 1);

  logic          busy_q, busy_d;
  logic          keep_q, keep_d;
  logic          err_q, err_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          idle_hdr, granted, accept;

  assign idle_hdr = bus_i.inband && bus_i.data[IDLE_BIT];
  assign granted  = bus_i.inband || bus_i.avail;
  assign accept   = granted && !idle_hdr && room_i;

  always_comb begin
    op_o   = '0;
    busy_d = busy_q;
    keep_d = keep_q;
    cnt_d  = cnt_q;
    err_d  = err_q;
    if (bus_i.sop) begin
      // restart framing; an unfinished kept packet is erased
      err_d       = err_q | busy_q;
      op_o.abort  = busy_q && keep_q;
      op_o.start  = accept;
      busy_d      = 1'b1;
      keep_d      = accept;
      cnt_d       = CW'(1);
    end else if (busy_q) begin
      op_o.push = keep_q;
      if (cnt_q == LAST) begin
        op_o.commit = keep_q;
        busy_d      = 1'b0;
        keep_d      = 1'b0;
        cnt_d       = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      keep_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      keep_q <= keep_d;
      err_q  <= err_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wdata_o = bus_i.data;
  assign hold_o  = busy_q && keep_q;
  assign err_o   = err_q;

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  a_r9_sop_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_i.sop |=> (busy_q && cnt_q == CW'(1)));

  a_r4_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !bus_i.sop && cnt_q != LAST) |=> (busy_q && cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
  import pkt_rx_pkg::*;
#(
  parameter int PKT_WORDS = 16,
  parameter int FIFO_PKTS = 2,
  localparam int DEPTH = PKT_WORDS * FIFO_PKTS,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fifo_op_t      op_i,
  input  word_t         wdata_i,
  input  logic          rd_i,
  output word_t         rd_data_o,
  output logic          empty_o,
  output logic [PW-1:0] free_o
);
  word_t         mem [DEPTH];
  logic [PW-1:0] wr_q, cmt_q, rd_q;
  logic [PW-1:0] wr_d, cmt_d, rd_d;
  logic [AW-1:0] waddr;
  logic          we, pop;

  assign we    = op_i.start || op_i.push;
  assign waddr = op_i.start ? cmt_q[AW-1:0] : wr_q[AW-1:0];
  assign pop   = rd_i && !empty_o;

  always_comb begin
    wr_d  = wr_q;
    cmt_d = cmt_q;
    rd_d  = rd_q;
    // a new or aborted packet rewinds the speculative pointer
    if (op_i.abort || op_i.start) wr_d = cmt_q + PW'(op_i.start);
    else if (op_i.push)           wr_d = wr_q + 1'b1;
    if (op_i.commit)              cmt_d = wr_q + 1'b1;
    if (pop)                      rd_d = rd_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      cmt_q <= '0;
      rd_q  <= '0;
    end else begin
      wr_q  <= wr_d;
      cmt_q <= cmt_d;
      rd_q  <= rd_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we) mem[waddr] <= wdata_i;
  end

  assign rd_data_o = mem[rd_q[AW-1:0]];
  assign empty_o   = (rd_q == cmt_q);
  assign free_o    = PW'(DEPTH) - (cmt_q - rd_q);

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q - rd_q) <= PW'(DEPTH));

  a_r7_start_has_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.start |-> (free_o >= PW'(PKT_WORDS)));

  a_r10_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o) |=> (rd_q == $past(rd_q)));
endmodule

// File: rtl/pkt_rx_flow.sv
module pkt_rx_flow #(
  parameter int PKT_WORDS = 16,
  parameter int PW        = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] free_i,
  input  logic          hold_i,
  output logic          en_o
);
  logic [PW:0] need;
  logic        en_d;

  // a packet in flight already owns PKT_WORDS of the free space
  assign need = hold_i ? (PW+1)'(2 * PKT_WORDS) : (PW+1)'(PKT_WORDS);
  assign en_d = {1'b0, free_i} >= need;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else         en_o <= en_d;
  end

  a_r2_en_has_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> (free_i >= PW'(PKT_WORDS)));
endmodule

// File: rtl/pkt_ingress_rx.sv
module pkt_ingress_rx
  import pkt_rx_pkg::*;
#(
  parameter int PKT_WORDS = 16,
  parameter int FIFO_PKTS = 2,
  parameter int IDLE_BIT  = 31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        inband_i,
  input  logic        pkt_avail_i,
  input  logic        sop_i,
  input  logic [31:0] data_i,
  output logic        rx_en_o,
  output logic        proto_err_o,
  input  logic        rd_i,
  output logic [31:0] rd_data_o,
  output logic        rd_empty_o
);
  localparam int DEPTH = PKT_WORDS * FIFO_PKTS;
  localparam int PW    = $clog2(DEPTH) + 1;

  bus_in_t       bus_q;
  fifo_op_t      op;
  word_t         wdata;
  logic          hold, room;
  logic [PW-1:0] free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_q <= '0;
    else         bus_q <= '{sop: sop_i, avail: pkt_avail_i, inband: inband_i, data: data_i};
  end

  assign room = free >= PW'(PKT_WORDS);

  pkt_rx_frame #(.PKT_WORDS(PKT_WORDS), .IDLE_BIT(IDLE_BIT)) u_frame (
    .clk_i, .rst_ni,
    .bus_i   (bus_q),
    .room_i  (room),
    .op_o    (op),
    .wdata_o (wdata),
    .hold_o  (hold),
    .err_o   (proto_err_o)
  );

  pkt_rx_fifo #(.PKT_WORDS(PKT_WORDS), .FIFO_PKTS(FIFO_PKTS)) u_fifo (
    .clk_i, .rst_ni,
    .op_i      (op),
    .wdata_i   (wdata),
    .rd_i      (rd_i),
    .rd_data_o (rd_data_o),
    .empty_o   (rd_empty_o),
    .free_o    (free)
  );

  pkt_rx_flow #(.PKT_WORDS(PKT_WORDS), .PW(PW)) u_flow (
    .clk_i, .rst_ni,
    .free_i (free),
    .hold_i (hold),
    .en_o   (rx_en_o)
  );
endmodule

// File: tb/pkt_ingress_rx_tb.sv
module pkt_ingress_rx_tb;
  localparam int N = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inband_i = 1'b0;
  logic        pkt_avail_i = 1'b0;
  logic        sop_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        rd_i = 1'b0;
  logic        rx_en_o, proto_err_o, rd_empty_o;
  logic [31:0] rd_data_o;

  int   n_run = 0;
  int   n_fail = 0;
  logic en_seen  [N];
  logic err_seen [N];
  logic empty_tail;

  always #10 clk_i = ~clk_i;

  pkt_ingress_rx u_dut (
    .clk_i, .rst_ni, .inband_i, .pkt_avail_i, .sop_i, .data_i,
    .rx_en_o, .proto_err_o, .rd_i, .rd_data_o, .rd_empty_o
  );

  // {inband, avail, idle header, expect stored}
  localparam logic [3:0] VEC [6] = '{
    4'b0101,  // R4 plain packet
    4'b0000,  // R5 no availability in handshake mode
    4'b0111,  // R8 idle header kept in handshake mode
    4'b1110,  // R8 idle header discarded in in-band mode
    4'b1001,  // R8 availability ignored in in-band mode
    4'b1101   // R4 plain packet in in-band mode
  };

  function automatic logic [31:0] word_of(input bit idle, input logic [7:0] tag, input int i);
    return {idle, 7'd0, 8'd0, tag, 8'(i)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_pkt(input bit idle, input logic [7:0] tag, input int nw);
    for (int i = 0; i < nw; i++) begin
      @(negedge clk_i);
      en_seen[i]  = rx_en_o;
      err_seen[i] = proto_err_o;
      sop_i  = (i == 0);
      data_i = word_of(idle, tag, i);
    end
    @(negedge clk_i);
    empty_tail = rd_empty_o;
    sop_i  = 1'b0;
    data_i = '0;
  endtask

  task automatic drain_pkt(input bit idle, input logic [7:0] tag, input string req);
    int          bad = 0;
    logic [31:0] act = '0;
    logic [31:0] exp = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_empty_o || rd_data_o != word_of(idle, tag, i)) begin
        if (bad == 0) begin
          act = rd_empty_o ? 32'hEEEE_EEEE : rd_data_o;
          exp = word_of(idle, tag, i);
        end
        bad++;
      end
      rd_i = 1'b1;
      @(negedge clk_i);
    end
    rd_i = 1'b0;
    check(bad == 0, req, act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R4 watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(rx_en_o == 1'b0, "R1 enable in reset", 32'(rx_en_o), 0);
    check(proto_err_o == 1'b0, "R1 error in reset", 32'(proto_err_o), 0);
    check(rd_empty_o == 1'b1, "R1 empty in reset", 32'(rd_empty_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(rx_en_o == 1'b1, "R1 R2 enable after reset with avail low", 32'(rx_en_o), 1);

    for (int v = 0; v < 6; v++) begin
      string lbl;
      lbl = (v == 1) ? "R5" : ((v >= 2 && v <= 4) ? "R8" : "R4");
      inband_i    = VEC[v][3];
      pkt_avail_i = VEC[v][2];
      repeat (3) @(negedge clk_i);
      send_pkt(VEC[v][1], 8'(v + 1), N);
      check(empty_tail == 1'b1, "R4 not readable one edge after last word", 32'(empty_tail), 1);
      @(negedge clk_i);
      check(rd_empty_o == !VEC[v][0], lbl, 32'(rd_empty_o), 32'(!VEC[v][0]));
      if (VEC[v][0]) drain_pkt(VEC[v][1], 8'(v + 1), lbl);
      check(rd_empty_o == 1'b1, lbl, 32'(rd_empty_o), 1);
    end

    // R6 stray words
    inband_i = 1'b0; pkt_avail_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      sop_i = 1'b0; data_i = 32'hDEAD_0000 + 32'(i);
    end
    @(negedge clk_i); data_i = '0;
    repeat (3) @(negedge clk_i);
    check(rd_empty_o == 1'b1, "R6 stray words ignored", 32'(rd_empty_o), 1);

    // fill: A then B, C dropped
    send_pkt(0, 8'hA0, N);
    check(en_seen[3] == 1'b1, "R2 enable stays with room for two", 32'(en_seen[3]), 1);
    @(negedge clk_i);
    send_pkt(0, 8'hB0, N);
    check(en_seen[2] == 1'b1, "R3 enable before third edge", 32'(en_seen[2]), 1);
    check(en_seen[3] == 1'b0, "R3 enable low at third edge", 32'(en_seen[3]), 0);
    repeat (2) @(negedge clk_i);
    send_pkt(0, 8'hC0, N);
    repeat (2) @(negedge clk_i);
    check(rx_en_o == 1'b0, "R2 enable low when full", 32'(rx_en_o), 0);
    drain_pkt(0, 8'hA0, "R4 first packet order");
    check(rx_en_o == 1'b0, "R10 enable one edge behind pop", 32'(rx_en_o), 0);
    @(negedge clk_i);
    check(rx_en_o == 1'b1, "R10 enable recovers", 32'(rx_en_o), 1);
    drain_pkt(0, 8'hB0, "R4 packet captured while enable low");
    check(rd_empty_o == 1'b1, "R7 packet without room dropped", 32'(rd_empty_o), 1);

    // R9 start strobe inside a packet
    send_pkt(0, 8'hE0, 5);
    send_pkt(0, 8'hD0, N);
    check(err_seen[1] == 1'b0, "R9 error not before second edge", 32'(err_seen[1]), 0);
    check(err_seen[2] == 1'b1, "R9 error at second edge", 32'(err_seen[2]), 1);
    @(negedge clk_i);
    drain_pkt(0, 8'hD0, "R9 new packet intact");
    check(rd_empty_o == 1'b1, "R9 partial packet erased", 32'(rd_empty_o), 1);
    repeat (4) @(negedge clk_i);
    check(proto_err_o == 1'b1, "R9 error sticky", 32'(proto_err_o), 1);

    rst_ni = 1'b0;
    @(negedge clk_i);
    check(proto_err_o == 1'b0, "R1 reset clears error", 32'(proto_err_o), 0);
    check(rx_en_o == 1'b0, "R1 reset clears enable", 32'(rx_en_o), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule